// File: doc/BRIEF.md
# Thermal Sensor Scan Controller

This block watches up to four on-die temperature sensors without software help. Once its run bit is set it walks the enabled sensor channels in ascending order. For each channel it asks an external converter for one 12-bit sample over a request/done handshake and keeps the result in a readable data register. It then compares the result against two limits for that channel, a warning limit and a trip limit. On these sensors a hotter die gives a smaller code, so "past a limit" means the code is less than or equal to the limit.

Each limit has its own debounce. The warning path raises a sticky pending bit, and through it the interrupt line, only after a run of consecutive over-limit samples of the programmed length. The trip path works the same way, but it latches a per-channel trip flag until reset. Each channel can send that flag to a reset-unit output, to a pin output, or to both, and one polarity bit sets the active level of both outputs. While any enabled channel is past either limit, the pause between scans uses a separate, shorter period. Pauses are counted in ticks of a prescaled time base. With the run bit clear, software can start single conversions through a register. The results of those conversions are stored but not compared.

Top module: `thermal_scan_ctrl`

## Requirements
- R1: After reset every data register reads 0, the interrupt is low, both trip outputs sit at their inactive level (high, since the polarity bit resets to 0), both debounce registers read 4, the normal period reads 250 and the hot period reads 50.
- R2: Register map (16-bit, word addresses): 0x00 control, with bit 0 run, bits 7:4 channel enables and bit 8 trip polarity (1 = active high). 0x04 routing, with bits 3:0 interrupt enables, bits 7:4 trip-to-pin and bits 11:8 trip-to-reset. 0x08 pending (write 1 to clear). 0x0C warning debounce, 0x10 trip debounce, 0x14 normal period, 0x18 hot period, 0x1C single-shot start (bit 0 start, bits 5:4 channel). Data registers are at 0x20+4*ch, warning limits at 0x40+4*ch and trip limits at 0x60+4*ch.
- R3: The converter request stays high with a stable channel until done. The sample on the done cycle lands in that channel's data register, and data registers change only after a done.
- R4: With run set, the enabled channels are converted in ascending order starting from channel 1. Channel 0 is never requested by a scan, even when its enable bit is set.
- R5: Between scans the request stays low for exactly period*TICK_DIV cycles. The normal period applies when no enabled channel's last sample was past a limit; otherwise the hot period applies.
- R6: A sample is over the warning limit when code <= limit. The pending bit is set on the sample that brings the count of consecutive over-limit samples to the debounce value. A sample that is not over the limit resets the count.
- R7: Writing 1 to a pending bit clears it. The interrupt is the OR of pending bits ANDed with their enables.
- R8: The trip path debounces the same way against the trip limit. Once set, the trip flag stays set until reset, even after the samples cool down.
- R9: The pin output is active when a tripped channel is routed to the pin, and the reset output is active when one is routed to reset. The active level is chosen by the polarity bit.
- R10: Clearing run during a conversion lets that conversion finish and store its sample, then no further request is made. Limits keep their values.
- R11: With run clear, writing start to 0x1C converts the chosen channel once and stores its sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational from bus_addr) |
| adc_req | output | 1 | Conversion request, held until adc_done |
| adc_ch | output | 2 | Channel being converted |
| adc_done | input | 1 | One-cycle completion pulse from converter |
| adc_data | input | 12 | Conversion result, valid with adc_done |
| irq | output | 1 | Warning interrupt |
| shut_rst | output | 1 | Trip output to reset unit |
| shut_pin | output | 1 | Trip output to pin |

## Verification
The hardest situation to reach is a trip debounce that is broken partway through and then restarted, because from the ports only a long, exact run of samples on one channel reveals the counter. The stimulus enables a single channel and feeds it a fixed table of codes, one per scan. The table places samples exactly on each limit, interrupts a run of trip samples one short of the count, and then cools the channel after the trip to show the latch. Clearing run in the middle of a conversion is reached by waiting until a request is pending and not yet done before writing control.

// File: rtl/tsm_pkg.sv
// Shared constants for the thermal scan controller: sizes, register
// addresses, field positions and the sequencer state type.
package tsm_pkg;
    localparam int NCH    = 4;
    localparam int CODE_W = 12;
    localparam int DEB_W  = 8;
    localparam int PER_W  = 16;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int CH_W   = $clog2(NCH);

    localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] A_ROUTE  = 8'h04;
    localparam logic [ADDR_W-1:0] A_PEND   = 8'h08;
    localparam logic [ADDR_W-1:0] A_ADEB   = 8'h0C;
    localparam logic [ADDR_W-1:0] A_SDEB   = 8'h10;
    localparam logic [ADDR_W-1:0] A_PNORM  = 8'h14;
    localparam logic [ADDR_W-1:0] A_PHOT   = 8'h18;
    localparam logic [ADDR_W-1:0] A_SWCONV = 8'h1C;

    localparam logic [2:0] BANK_DATA = 3'd1;
    localparam logic [2:0] BANK_ATH  = 3'd2;
    localparam logic [2:0] BANK_STH  = 3'd3;

    localparam int EN_LSB  = 4;
    localparam int POL_BIT = 8;
    localparam int PIN_LSB = 4;
    localparam int RST_LSB = 8;
    localparam int SWC_LSB = 4;

    localparam logic [DEB_W-1:0] DEB_RST   = 8'd4;
    localparam logic [PER_W-1:0] PNORM_RST = 16'd250;
    localparam logic [PER_W-1:0] PHOT_RST  = 16'd50;

    typedef enum logic [1:0] {S_IDLE, S_CONV, S_WAIT} seq_st_t;
endpackage

// File: rtl/tsm_seq.sv
// Scan sequencer: walks enabled channels 1..NCH-1 in ascending order,
// runs the converter handshake, and waits a prescaled period between scans.
// Assumes adc_done is a one-cycle pulse returned only while adc_req is high.
module tsm_seq
    import tsm_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [NCH-1:0]   ch_en,
    input  logic             hot,
    input  logic [PER_W-1:0] per_norm,
    input  logic [PER_W-1:0] per_hot,
    input  logic             sw_start,
    input  logic [CH_W-1:0]  sw_ch,
    input  logic             adc_done,
    output logic             adc_req,
    output logic [CH_W-1:0]  adc_ch,
    output logic             smp_vld,
    output logic             smp_auto
);
    localparam int DIV_W = $clog2(TICK_DIV + 1);

    seq_st_t          st;
    logic [CH_W-1:0]  cur_ch, first_idx, nxt_idx;
    logic             first_ok, nxt_ok, is_auto, tick, period_done;
    logic [DIV_W-1:0] pcnt;
    logic [PER_W-1:0] tcnt, limit;

    // Find the lowest enabled scan channel and the next one after cur_ch.
    always_comb begin
        first_ok = 1'b0; first_idx = '0;
        nxt_ok   = 1'b0; nxt_idx   = '0;
        for (int i = NCH - 1; i >= 1; i--) begin
            if (ch_en[i]) begin
                first_ok = 1'b1; first_idx = CH_W'(i);
            end
            if (ch_en[i] && i > int'(cur_ch)) begin
                nxt_ok = 1'b1; nxt_idx = CH_W'(i);
            end
        end
    end

    assign tick        = (st == S_WAIT) && (pcnt == DIV_W'(TICK_DIV - 1));
    assign limit       = hot ? per_hot : per_norm;
    assign period_done = ({1'b0, tcnt} + 1'b1) >= {1'b0, limit};

    // Scan state machine with interval timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; cur_ch <= '0; is_auto <= 1'b0; pcnt <= '0; tcnt <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    pcnt <= '0; tcnt <= '0;
                    if (run) begin
                        is_auto <= 1'b1;
                        if (first_ok) begin st <= S_CONV; cur_ch <= first_idx; end
                        else st <= S_WAIT;
                    end else if (sw_start) begin
                        st <= S_CONV; cur_ch <= sw_ch; is_auto <= 1'b0;
                    end
                end
                S_CONV: begin
                    if (adc_done) begin
                        if (!is_auto || !run) st <= S_IDLE;
                        else if (nxt_ok) cur_ch <= nxt_idx;
                        else begin st <= S_WAIT; pcnt <= '0; tcnt <= '0; end
                    end
                end
                S_WAIT: begin
                    if (!run) st <= S_IDLE;
                    else if (tick) begin
                        pcnt <= '0;
                        if (period_done) begin
                            tcnt <= '0;
                            if (first_ok) begin st <= S_CONV; cur_ch <= first_idx; end
                        end else tcnt <= tcnt + 1'b1;
                    end else pcnt <= pcnt + 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign adc_req  = (st == S_CONV);
    assign adc_ch   = cur_ch;
    assign smp_vld  = (st == S_CONV) && adc_done;
    assign smp_auto = is_auto;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req && !adc_done |=> adc_req && $stable(adc_ch)); // R3
    AST_NO_CH0_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req && is_auto |-> adc_ch != '0); // R4
    AST_STOP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req && adc_done && !run |=> !adc_req); // R10
endmodule

// File: rtl/tsm_chan.sv
// Per-channel evaluator: debounces warning and trip conditions over
// consecutive scan samples, holds the pending bit and the latched trip flag.
// Assumes smp pulses once per scan sample of this channel.
module tsm_chan
    import tsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] alm_th,
    input  logic [CODE_W-1:0] sht_th,
    input  logic [DEB_W-1:0]  alm_deb,
    input  logic [DEB_W-1:0]  sht_deb,
    input  logic              clr_pend,
    output logic              pend,
    output logic              shut_hit,
    output logic              hot
);
    logic [DEB_W-1:0] acnt, scnt, a_next, s_next;
    logic             over_a, over_s;

    assign over_a = code <= alm_th;
    assign over_s = code <= sht_th;
    assign a_next = !over_a ? '0 : (&acnt ? acnt : acnt + 1'b1);
    assign s_next = !over_s ? '0 : (&scnt ? scnt : scnt + 1'b1);

    // Debounce counters, hot flag and trip latch, updated per sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acnt <= '0; scnt <= '0; hot <= 1'b0; shut_hit <= 1'b0;
        end else if (smp) begin
            acnt <= a_next;
            scnt <= s_next;
            hot  <= over_a || over_s;
            if (over_s && s_next >= sht_deb) shut_hit <= 1'b1;
        end
    end

    // Pending bit: set by a completed warning debounce, cleared by write-1.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else if (smp && over_a && a_next >= alm_deb) pend <= 1'b1;
        else if (clr_pend) pend <= 1'b0;
    end

    AST_PEND_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(smp)); // R6
    AST_TRIP_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shut_hit) |-> $past(smp)); // R8
endmodule

// File: rtl/thermal_scan_ctrl.sv
// Thermal scan controller top: register file, result storage, output
// routing and polarity. Assumes a single-cycle write strobe and a
// combinational read of the addressed register.
module thermal_scan_ctrl
    import tsm_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              adc_req,
    output logic [CH_W-1:0]   adc_ch,
    input  logic              adc_done,
    input  logic [CODE_W-1:0] adc_data,
    output logic              irq,
    output logic              shut_rst,
    output logic              shut_pin
);
    logic                    run, pol, smp_vld, smp_auto, sw_start, hot;
    logic                    in_bank, pin_act, rst_act;
    logic [NCH-1:0]          ch_en, ien, pin_rt, rst_rt, pend, shut_hit, hot_v, clr;
    logic [DEB_W-1:0]        alm_deb, sht_deb;
    logic [PER_W-1:0]        per_norm, per_hot;
    logic [CODE_W-1:0]       data_q [NCH];
    logic [CODE_W-1:0]       ath_q  [NCH];
    logic [CODE_W-1:0]       sth_q  [NCH];
    logic [NCH*CODE_W-1:0]   data_flat;
    logic [2:0]              bank;
    logic [CH_W-1:0]         bidx;

    assign bank     = bus_addr[7:5];
    assign bidx     = bus_addr[CH_W+1:2];
    assign in_bank  = (bus_addr[4] == 1'b0) && (bus_addr[1:0] == 2'b00);
    assign sw_start = bus_wr && (bus_addr == A_SWCONV) && bus_wdata[0];
    assign clr      = (bus_wr && bus_addr == A_PEND) ? bus_wdata[NCH-1:0] : '0;

    // Configuration and limit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0; ch_en <= '0; pol <= 1'b0;
            ien <= '0; pin_rt <= '0; rst_rt <= '0;
            alm_deb <= DEB_RST; sht_deb <= DEB_RST;
            per_norm <= PNORM_RST; per_hot <= PHOT_RST;
            for (int i = 0; i < NCH; i++) begin ath_q[i] <= '0; sth_q[i] <= '0; end
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL: begin
                    run <= bus_wdata[0]; pol <= bus_wdata[POL_BIT];
                    ch_en <= bus_wdata[EN_LSB +: NCH];
                end
                A_ROUTE: begin
                    ien <= bus_wdata[0 +: NCH];
                    pin_rt <= bus_wdata[PIN_LSB +: NCH];
                    rst_rt <= bus_wdata[RST_LSB +: NCH];
                end
                A_ADEB:  alm_deb  <= bus_wdata[DEB_W-1:0];
                A_SDEB:  sht_deb  <= bus_wdata[DEB_W-1:0];
                A_PNORM: per_norm <= bus_wdata;
                A_PHOT:  per_hot  <= bus_wdata;
                default: begin
                    if (in_bank && bank == BANK_ATH) ath_q[bidx] <= bus_wdata[CODE_W-1:0];
                    if (in_bank && bank == BANK_STH) sth_q[bidx] <= bus_wdata[CODE_W-1:0];
                end
            endcase
        end
    end

    // Result capture on each accepted conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) data_q[i] <= '0;
        end else if (smp_vld) begin
            data_q[adc_ch] <= adc_data;
        end
    end

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[0] = run; bus_rdata[POL_BIT] = pol;
                bus_rdata[EN_LSB +: NCH] = ch_en;
            end
            A_ROUTE: begin
                bus_rdata[0 +: NCH] = ien;
                bus_rdata[PIN_LSB +: NCH] = pin_rt;
                bus_rdata[RST_LSB +: NCH] = rst_rt;
            end
            A_PEND:  bus_rdata[NCH-1:0] = pend;
            A_ADEB:  bus_rdata[DEB_W-1:0] = alm_deb;
            A_SDEB:  bus_rdata[DEB_W-1:0] = sht_deb;
            A_PNORM: bus_rdata = per_norm;
            A_PHOT:  bus_rdata = per_hot;
            default: begin
                if (in_bank) begin
                    case (bank)
                        BANK_DATA: bus_rdata[CODE_W-1:0] = data_q[bidx];
                        BANK_ATH:  bus_rdata[CODE_W-1:0] = ath_q[bidx];
                        BANK_STH:  bus_rdata[CODE_W-1:0] = sth_q[bidx];
                        default:   bus_rdata = '0;
                    endcase
                end
            end
        endcase
    end

    tsm_seq #(.TICK_DIV(TICK_DIV)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .ch_en(ch_en), .hot(hot),
        .per_norm(per_norm), .per_hot(per_hot), .sw_start(sw_start),
        .sw_ch(bus_wdata[SWC_LSB +: CH_W]), .adc_done(adc_done),
        .adc_req(adc_req), .adc_ch(adc_ch), .smp_vld(smp_vld), .smp_auto(smp_auto)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tsm_chan u_chan (
            .clk(clk), .rst_n(rst_n),
            .smp(smp_vld && smp_auto && adc_ch == CH_W'(g)),
            .code(adc_data), .alm_th(ath_q[g]), .sht_th(sth_q[g]),
            .alm_deb(alm_deb), .sht_deb(sht_deb), .clr_pend(clr[g]),
            .pend(pend[g]), .shut_hit(shut_hit[g]), .hot(hot_v[g])
        );
        assign data_flat[g*CODE_W +: CODE_W] = data_q[g];
    end

    assign hot      = |(hot_v & ch_en & ~NCH'(1));
    assign irq      = |(pend & ien);
    assign pin_act  = |(shut_hit & pin_rt);
    assign rst_act  = |(shut_hit & rst_rt);
    assign shut_pin = pol ? pin_act : ~pin_act;
    assign shut_rst = pol ? rst_act : ~rst_act;

    AST_DATA_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(adc_done) |-> $stable(data_flat)); // R3
endmodule

// File: tb/sim_thermal_scan_ctrl.sv
`timescale 1ns/1ps
module sim_thermal_scan_ctrl;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0, rdata;
    logic        adc_req, adc_done = 1'b0;
    logic [1:0]  adc_ch;
    logic [11:0] adc_data = '0;
    logic        irq, shut_rst, shut_pin;
    logic [11:0] code_v [4];
    int          mcnt = 0, errors = 0, checks = 0;
    bit          scan_mode = 1'b0, ch0_seen = 1'b0;

    always #2.5 clk = ~clk;

    thermal_scan_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .adc_req(adc_req), .adc_ch(adc_ch), .adc_done(adc_done),
        .adc_data(adc_data), .irq(irq), .shut_rst(shut_rst), .shut_pin(shut_pin)
    );

    // Converter model: done three cycles into each request.
    initial forever begin
        @(posedge clk);
        if (!rst_n) begin adc_done <= 1'b0; mcnt <= 0; end
        else if (adc_req && !adc_done) begin
            if (mcnt == 2) begin adc_done <= 1'b1; adc_data <= code_v[adc_ch]; mcnt <= 0; end
            else mcnt <= mcnt + 1;
        end else adc_done <= 1'b0;
    end

    initial forever begin
        @(negedge clk);
        if (scan_mode && adc_req && adc_ch == 2'd0) ch0_seen = 1'b1;
    end

    // Each entry: {code for channel 1, expected irq, expected pin trip}.
    localparam logic [13:0] VEC [12] = '{
        {12'd2500, 1'b0, 1'b0}, {12'd1900, 1'b0, 1'b0}, {12'd2100, 1'b0, 1'b0},
        {12'd2000, 1'b0, 1'b0}, {12'd1999, 1'b1, 1'b0}, {12'd1500, 1'b1, 1'b0},
        {12'd1400, 1'b1, 1'b0}, {12'd1600, 1'b1, 1'b0}, {12'd1500, 1'b1, 1'b0},
        {12'd1500, 1'b1, 1'b0}, {12'd1500, 1'b1, 1'b1}, {12'd3000, 1'b1, 1'b1}
    };

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [7:0] a, output int v);
        addr = a; #1 v = int'(rdata);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr = 1'b0;
        for (int i = 0; i < 4; i++) code_v[i] = 12'd4000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_done(output int ch);
        do @(negedge clk); while (!adc_done);
        ch = int'(adc_ch);
    endtask

    task automatic gap(output int g);
        g = 0;
        @(negedge clk);
        while (!adc_req) begin g++; @(negedge clk); end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int v, c, c1, c2, c3, hi;
        do_reset();
        // R1: reset state
        rreg(8'h24, v); chk(v, 0, "R1 data");
        chk(int'(irq), 0, "R1 irq");
        chk(int'(shut_pin), 1, "R1 pin idle");
        chk(int'(shut_rst), 1, "R1 rst idle");
        rreg(8'h0C, v); chk(v, 4, "R1 warn deb");
        rreg(8'h10, v); chk(v, 4, "R1 trip deb");
        rreg(8'h14, v); chk(v, 250, "R1 norm period");
        rreg(8'h18, v); chk(v, 50, "R1 hot period");

        // R6 R8 R9: table walk on channel 1, polarity high
        wreg(8'h44, 16'd2000); wreg(8'h64, 16'd1500);
        wreg(8'h0C, 16'd2); wreg(8'h10, 16'd3);
        wreg(8'h14, 16'd2); wreg(8'h18, 16'd1);
        wreg(8'h04, 16'h0022);
        code_v[1] = 12'd2500;
        wreg(8'h00, 16'h0121);
        for (int i = 0; i < 12; i++) begin
            code_v[1] = VEC[i][13:2];
            wait_done(c);
            @(negedge clk);
            chk(int'(irq), int'(VEC[i][1]), "R6 warn debounce");
            chk(int'(shut_pin), int'(VEC[i][0]), "R8 trip debounce");
            chk(int'(shut_rst), 0, "R9 reset path unrouted");
        end
        // R7: write-1 clear
        wreg(8'h08, 16'h0002);
        chk(int'(irq), 0, "R7 irq after clear");
        rreg(8'h08, v); chk(v, 0, "R7 pending after clear");
        rreg(8'h24, v); chk(v, 3000, "R3 stored sample");

        // R4 R2: scan order, channel 0 skipped
        do_reset();
        code_v[0] = 12'd3500; code_v[1] = 12'd3001; code_v[2] = 12'd3002; code_v[3] = 12'd3003;
        scan_mode = 1'b1;
        wreg(8'h00, 16'h00F1);
        wait_done(c1); wait_done(c2); wait_done(c3);
        chk(c1, 1, "R4 first channel");
        chk(c2, 2, "R4 second channel");
        chk(c3, 3, "R4 third channel");
        repeat (60) @(negedge clk);
        chk(int'(ch0_seen), 0, "R4 channel 0 never scanned");
        scan_mode = 1'b0;
        rreg(8'h28, v); chk(v, 3002, "R2 data register ch2");
        rreg(8'h2C, v); chk(v, 3003, "R2 data register ch3");
        rreg(8'h20, v); chk(v, 0, "R2 channel 0 data untouched");

        // R5: normal and hot intervals
        do_reset();
        wreg(8'h44, 16'd2000); wreg(8'h14, 16'd5); wreg(8'h18, 16'd2);
        code_v[1] = 12'd3000;
        wreg(8'h00, 16'h0021);
        wait_done(c); gap(v); chk(v, 20, "R5 normal interval");
        code_v[1] = 12'd1900;
        wait_done(c); gap(v); chk(v, 8, "R5 hot interval");

        // R9 R8: routing with active-low polarity, latch after cooling
        do_reset();
        wreg(8'h64, 16'd1500); wreg(8'h68, 16'd1500); wreg(8'h14, 16'd1);
        wreg(8'h04, 16'h0420);
        code_v[1] = 12'd1000; code_v[2] = 12'd3000;
        wreg(8'h00, 16'h0061);
        for (int i = 0; i < 12; i++) wait_done(c);
        @(negedge clk);
        chk(int'(shut_pin), 0, "R9 pin active low");
        chk(int'(shut_rst), 1, "R9 reset idle");
        code_v[2] = 12'd1000;
        for (int i = 0; i < 12; i++) wait_done(c);
        @(negedge clk);
        chk(int'(shut_rst), 0, "R9 reset active low");
        code_v[1] = 12'd3000; code_v[2] = 12'd3000;
        for (int i = 0; i < 8; i++) wait_done(c);
        @(negedge clk);
        chk(int'(shut_pin), 0, "R8 trip stays latched");

        // R10: stop during a conversion
        do_reset();
        wreg(8'h44, 16'd777); wreg(8'h14, 16'd1);
        code_v[1] = 12'd1234;
        wreg(8'h00, 16'h0021);
        do @(negedge clk); while (!(adc_req && !adc_done));
        wreg(8'h00, 16'h0020);
        repeat (10) @(negedge clk);
        hi = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (adc_req) hi++; end
        chk(hi, 0, "R10 no request after stop");
        rreg(8'h24, v); chk(v, 1234, "R10 last sample stored");
        rreg(8'h44, v); chk(v, 777, "R10 limit retained");

        // R11: single-shot conversion with run clear
        code_v[2] = 12'd2222;
        wreg(8'h1C, 16'h0021);
        wait_done(c);
        chk(c, 2, "R11 requested channel");
        @(negedge clk);
        rreg(8'h28, v); chk(v, 2222, "R11 sample stored");

        finish_run();
    end
endmodule